// File: doc/BRIEF.md
# GPIO Pin Interrupt Unit

This unit watches a bank of eight general-purpose input pins and turns their activity into interrupts. Each pin has its own 3-bit trigger mode. A pin can be switched off, follow a high or low level, be forced to assert, or latch rising, falling or both edges. A latched edge stays pending until software clears it. Each pin input is first synchronised into the clock domain. Edges are then found by comparing the synchronised value with its value one cycle earlier.

Software reaches the unit over a simple 32-bit memory-mapped bus. The bus has a combinational read port and a write strobe. Through it, software programs the trigger modes and a per-pin enable mask, clears latched edges by writing ones, and reads the raw and the masked status separately. A single registered line, the OR of all masked status bits, goes to the system interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the mode register (byte offset 12) and the mask register (offset 16) read zero, the raw status (offset 24) and masked status (offset 28) read zero, and `irqOut` is low.
- R2: The mode register holds pin i's mode in bits 3i+2:3i (pin 0 in 2:0, pin 7 in 23:21). Bits 31:24 always read zero.
- R3: The mask register keeps bits 7:0, where bit i = 1 enables pin i. Bits 31:8 read zero.
- R4: In mode 1 the raw bit equals the synchronised pin level. In mode 2 it equals the inverse of that level. Both follow the pin within three clocks.
- R5: Mode 3 holds the raw bit at 1 and mode 0 holds it at 0, whatever the pin does.
- R6: Modes 4 to 7 are edge modes. Mode code bit 0 selects rising edges and bit 1 selects falling edges, so 5 = rising, 6 = falling, 7 = any edge, and 4 catches none. A caught edge sets the raw bit, and the bit stays set while the pin keeps moving.
- R7: Writing offset 20 with bit i = 1 clears pin i's latched edge. Bits written as 0 leave their pins alone. Offset 20 reads zero.
- R8: If an edge is detected in the same cycle that an acknowledge for that pin is written, the raw bit stays set.
- R9: Masked status reads raw status AND mask.
- R10: `irqOut` equals the OR of the masked status bits one clock earlier.
- R11: Reads of unmapped offsets return zero. Writes to offsets 24, 28 and unmapped offsets change no register.
- R12: Moving a pin out of the edge modes (to a code below 4) discards its latched edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| pinIn | input | 8 | Raw asynchronous pin inputs |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The assertions take the bus as well-formed: a write is one strobe with a stable address and data across the sampling edge. They also assume a pin that triggers an edge stays at its new level for at least two clocks, so the synchroniser passes every transition through. The bench drives the bus and pins only at falling clock edges, holds each write for exactly one rising edge, and leaves pins steady for several clocks between changes. The edge-versus-acknowledge case is the one place where a write is aimed at a specific cycle. There the pin change and the write are placed so that the edge detection and the acknowledge land on the same rising edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int PIN_COUNT = 8;
  localparam int MODE_W    = 3;
  localparam int CFG_W     = PIN_COUNT * MODE_W;

  localparam int OFS_MODE   = 12;
  localparam int OFS_ENABLE = 16;
  localparam int OFS_CLEAR  = 20;
  localparam int OFS_RAW    = 24;
  localparam int OFS_MASKED = 28;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF       = 3'd0,
    TRIG_LEVEL_HI  = 3'd1,
    TRIG_LEVEL_LO  = 3'd2,
    TRIG_FORCE     = 3'd3,
    TRIG_EDGE_NONE = 3'd4,
    TRIG_RISE      = 3'd5,
    TRIG_FALL      = 3'd6,
    TRIG_BOTH      = 3'd7
  } trigMode_e;

  // strobes from the register block to the status datapath
  typedef struct packed {
    logic [PIN_COUNT-1:0] clearPulse;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic [PIN_COUNT-1:0] rawStatus,
  input  logic [PIN_COUNT-1:0] maskedStatus,
  output logic [DATA_W-1:0]    busRdData,
  output logic [CFG_W-1:0]     cfgModes,
  output logic [PIN_COUNT-1:0] maskBits,
  output ctrlStrobe_t          strobe
);

  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] ADDR_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] ADDR_MASKED = ADDR_W'(OFS_MASKED);

  logic hitMode, hitEnable, hitClear;
  logic unusedWrBits;

  assign hitMode   = busWrEn && (busAddr == ADDR_MODE);
  assign hitEnable = busWrEn && (busAddr == ADDR_ENABLE);
  assign hitClear  = busWrEn && (busAddr == ADDR_CLEAR);
  assign unusedWrBits = ^busWrData[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgModes <= '0;
      maskBits <= '0;
    end else begin
      if (hitMode)   cfgModes <= busWrData[CFG_W-1:0];
      if (hitEnable) maskBits <= busWrData[PIN_COUNT-1:0];
    end
  end

  always_comb begin
    strobe = '0;
    strobe.clearPulse = hitClear ? busWrData[PIN_COUNT-1:0] : '0;
  end

  always_comb begin
    case (busAddr)
      ADDR_MODE:   busRdData = DATA_W'(cfgModes);
      ADDR_ENABLE: busRdData = DATA_W'(maskBits);
      ADDR_RAW:    busRdData = DATA_W'(rawStatus);
      ADDR_MASKED: busRdData = DATA_W'(maskedStatus);
      default:     busRdData = '0;
    endcase
  end

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADDR_RAW || busAddr == ADDR_MASKED))
      |=> ($stable(cfgModes) && $stable(maskBits))); // R11

  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn) |-> (strobe.clearPulse == '0)); // R7

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [CFG_W-1:0]     cfgModes,
  input  logic [PIN_COUNT-1:0] maskBits,
  input  ctrlStrobe_t          strobe,
  output logic [PIN_COUNT-1:0] rawStatus,
  output logic [PIN_COUNT-1:0] maskedStatus,
  output logic                 irqOut
);

  logic [PIN_COUNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_COUNT-1:0] syncedPin;
  logic [PIN_COUNT-1:0] prevPin;
  logic [PIN_COUNT-1:0] edgeLatch;
  logic [PIN_COUNT-1:0] edgeHit;
  trigMode_e            modeOf [PIN_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
      prevPin <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      prevPin <= syncChain[SYNC_STAGES-1];
    end
  end

  assign syncedPin = syncChain[SYNC_STAGES-1];

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic riseSeen, fallSeen;

    assign modeOf[i] = trigMode_e'(cfgModes[i*MODE_W +: MODE_W]);
    assign riseSeen  = modeOf[i][0] &  syncedPin[i] & ~prevPin[i];
    assign fallSeen  = modeOf[i][1] & ~syncedPin[i] &  prevPin[i];
    assign edgeHit[i] = modeOf[i][2] & (riseSeen | fallSeen);

    always_ff @(posedge clk) begin
      if (!rstN)              edgeLatch[i] <= 1'b0;
      else if (!modeOf[i][2]) edgeLatch[i] <= 1'b0;
      else edgeLatch[i] <= edgeHit[i] | (edgeLatch[i] & ~strobe.clearPulse[i]);
    end

    always_comb begin
      case (modeOf[i])
        TRIG_OFF:      rawStatus[i] = 1'b0;
        TRIG_LEVEL_HI: rawStatus[i] = syncedPin[i];
        TRIG_LEVEL_LO: rawStatus[i] = ~syncedPin[i];
        TRIG_FORCE:    rawStatus[i] = 1'b1;
        default:       rawStatus[i] = edgeLatch[i];
      endcase
    end

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> rawStatus[i] || !modeOf[i][2]); // R8

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (modeOf[i][2] && edgeLatch[i] && !strobe.clearPulse[i]) |=> edgeLatch[i]); // R6

    AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rstN)
      (modeOf[i] == TRIG_FORCE) |-> rawStatus[i]); // R5

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (modeOf[i] == TRIG_OFF) |-> !rawStatus[i]); // R5
  end

  assign maskedStatus = rawStatus & maskBits;

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |maskedStatus;
  end

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawStatus & maskBits)))); // R10

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic                 irqOut
);

  logic [CFG_W-1:0]     cfgModes;
  logic [PIN_COUNT-1:0] maskBits;
  logic [PIN_COUNT-1:0] rawStatus;
  logic [PIN_COUNT-1:0] maskedStatus;
  ctrlStrobe_t          strobe;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busAddr      (busAddr),
    .busWrEn      (busWrEn),
    .busWrData    (busWrData),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .busRdData    (busRdData),
    .cfgModes     (cfgModes),
    .maskBits     (maskBits),
    .strobe       (strobe)
  );

  gpio_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .pinIn        (pinIn),
    .cfgModes     (cfgModes),
    .maskBits     (maskBits),
    .strobe       (strobe),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irqOut       (irqOut)
  );

endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [7:0]  pinIn;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit i_gpio_irq_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] mask;
    logic [7:0] pinsA;
    logic [7:0] pinsB;
    logic [7:0] expRaw;
    logic [7:0] expMasked;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'd5, 8'hFF, 8'h00, 8'hA5, 8'hA5, 8'hA5},  // R6 rising
    '{3'd5, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00},  // R6 rising ignores fall
    '{3'd6, 8'hF0, 8'h3C, 8'h0F, 8'h30, 8'h30},  // R6 falling
    '{3'd7, 8'hFF, 8'h55, 8'h5A, 8'h0F, 8'h0F},  // R6 any edge
    '{3'd1, 8'h33, 8'h00, 8'hC3, 8'hC3, 8'h03},  // R4 level high
    '{3'd2, 8'hFF, 8'h00, 8'hC3, 8'h3C, 8'h3C},  // R4 level low
    '{3'd3, 8'h81, 8'h00, 8'h00, 8'hFF, 8'h81},  // R5 forced
    '{3'd0, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},  // R5 off
    '{3'd4, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00}   // R6 edge mode with no edge selected
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] fillMode(input logic [2:0] m);
    return {8'h00, {8{m}}};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0; pinIn = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    busRead(8'd12, rd); check("R1 mode reg", rd, 32'h0);
    busRead(8'd16, rd); check("R1 mask reg", rd, 32'h0);
    busRead(8'd24, rd); check("R1 raw", rd, 32'h0);
    busRead(8'd28, rd); check("R1 masked", rd, 32'h0);
    check("R1 irq", {31'd0, irqOut}, 32'h0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      pinIn = VECS[v].pinsA;
      idle(6);
      busWrite(8'd12, fillMode(VECS[v].mode));
      busWrite(8'd16, {24'h0, VECS[v].mask});
      busWrite(8'd20, 32'hFF);
      pinIn = VECS[v].pinsB;
      idle(6);
      busRead(8'd24, rd); check("R9 raw vector", rd, {24'h0, VECS[v].expRaw});
      busRead(8'd28, rd); check("R9 masked vector", rd, {24'h0, VECS[v].expMasked});
      check("R10 irq vector", {31'd0, irqOut}, {31'd0, |VECS[v].expMasked});
    end

    // R2 field layout and unused bits
    busWrite(8'd12, 32'hFFFF_FFFF);
    busRead(8'd12, rd); check("R2 upper bits", rd, 32'h00FF_FFFF);
    pinIn = 8'h00; idle(6);
    busWrite(8'd12, 32'h0060_0001);
    busRead(8'd24, rd); check("R2 pin7 set pin0 level", rd, 32'h80);
    pinIn = 8'h01; idle(4);
    busRead(8'd24, rd); check("R2 pin0 level", rd, 32'h81);

    // R3 mask width
    busWrite(8'd16, 32'hFFFF_FF5A);
    busRead(8'd16, rd); check("R3 mask readback", rd, 32'h5A);

    // R7 partial clear, R10 irq timing
    pinIn = 8'h00;
    busWrite(8'd16, 32'hFF);
    busWrite(8'd12, fillMode(3'd5));
    busWrite(8'd20, 32'hFF);
    pinIn = 8'hFF; idle(6);
    busWrite(8'd20, 32'h0F);
    busRead(8'd24, rd); check("R7 partial clear", rd, 32'hF0);
    busRead(8'd20, rd); check("R7 clear reads zero", rd, 32'h0);
    pinIn = 8'h00; idle(6);
    busRead(8'd24, rd); check("R6 latch holds through fall", rd, 32'hF0);
    @(negedge clk);
    busAddr = 8'd20; busWrData = 32'hFF; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = 8'd24;
    #1 check("R7 all cleared", busRdData, 32'h0);
    check("R10 irq lags one clock", {31'd0, irqOut}, 32'h1);
    @(negedge clk);
    #1 check("R10 irq drops", {31'd0, irqOut}, 32'h0);

    // R8 edge and clear in the same cycle
    busWrite(8'd12, fillMode(3'd5));
    busWrite(8'd20, 32'hFF);
    @(negedge clk);
    pinIn = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busAddr = 8'd20; busWrData = 32'h01; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(8'd24, rd); check("R8 edge wins", rd, 32'h01);
    busWrite(8'd20, 32'h01);
    busRead(8'd24, rd); check("R8 later clear", rd, 32'h0);

    // R12 leaving edge mode discards the latch
    pinIn = 8'h00; idle(4);
    busWrite(8'd20, 32'hFF);
    pinIn = 8'h02; idle(6);
    busRead(8'd24, rd); check("R12 latched before", rd, 32'h02);
    busWrite(8'd12, 32'h0);
    busWrite(8'd12, fillMode(3'd5));
    busRead(8'd24, rd); check("R12 latch discarded", rd, 32'h0);

    // R11 read-only and unmapped offsets
    busWrite(8'd12, 32'h0000_0FFF);
    busWrite(8'd16, 32'h0000_0033);
    busWrite(8'd24, 32'hFFFF_FFFF);
    busWrite(8'd28, 32'hFFFF_FFFF);
    busWrite(8'd4,  32'hFFFF_FFFF);
    busRead(8'd12, rd); check("R11 mode unchanged", rd, 32'h0FFF);
    busRead(8'd16, rd); check("R11 mask unchanged", rd, 32'h33);
    busRead(8'd4,  rd); check("R11 unmapped read", rd, 32'h0);
    busRead(8'd32, rd); check("R11 unmapped read 32", rd, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule